// File: doc/BRIEF.md
# Banked Byte-Lane SRAM Bus Subordinate

This block is an AHB subordinate that stores bus data in a memory built from byte-wide single-port SRAM arrays. The arrays are grouped into banks of four, and each bank serves one 32-bit word with one array per byte lane. The low lane holds the byte at the lowest byte address. Address, direction and size are taken from the bus in the address phase. Reads are launched into the arrays in that same cycle, so the word is ready in the data phase. Writes use the write data present in the data phase.

The block never inserts wait states, so it has only one memory port for a read that starts in one cycle and a write that finishes in the same cycle. When both need the port, the write is parked in a one-entry hold register. The held write goes to the array in the next cycle in which no read is launched. Until then, reads that hit the held word have its bytes merged into the returned data. A phase tracker with three states follows the bus: `S_IDLE` (no data phase of this block), `S_WDATA` (write data phase) and `S_RDATA` (read data phase). Every state moves on each clock. An accepted write goes to `S_WDATA`, an accepted read goes to `S_RDATA`, and anything else goes to `S_IDLE`.

Top module: `ahb_sram_banked`

## Requirements
- R1: After reset `hrdata` is 0, `hreadyout` is 1 and `hresp` is 0.
- R2: `hreadyout` is always 1 and `hresp` is always 0 (OKAY).
- R3: A word transfer (`hsize`=2) writes all four lanes. A later read of that word returns it, with bits 7:0 taken from byte offset 0 (little-endian).
- R4: A byte transfer (`hsize`=0) writes only the lane chosen by `haddr[1:0]`, taking bits 8*n+7:8*n of `hwdata` for lane n. Other lanes keep their contents.
- R5: A halfword transfer (`hsize`=1) writes lanes 1:0 when `haddr[1]`=0 and lanes 3:2 when `haddr[1]`=1.
- R6: With the default `WORD_AW`=8, `haddr[9:2]` selects the word and `haddr[10]` selects the bank. The two banks hold separate data for the same word index, and `haddr` bits above 10 are ignored (aliases).
- R7: A cycle with `hsel`=0, or with `htrans` IDLE (0) or BUSY (1), starts no transfer and changes no stored data.
- R8: A read whose address phase coincides with the data phase of a write returns the newly written bytes, including partial writes merged with older bytes. The held write later reaches the array.
- R9: `hrdata` is 0 in every cycle that is not a read data phase.
- R10: Write data is taken from `hwdata` in the data phase; the value on `hwdata` during the address phase is not used.
- R11: A cycle with `hready`=0 starts no transfer, even with `hsel`=1 and `htrans` NONSEQ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Active-low reset |
| hsel | input | 1 | Subordinate select |
| haddr | input | 32 | Byte address |
| htrans | input | 2 | Transfer type (0 IDLE, 1 BUSY, 2 NONSEQ, 3 SEQ) |
| hwrite | input | 1 | 1 for write, 0 for read |
| hsize | input | 3 | Transfer size (0 byte, 1 halfword, 2 word) |
| hwdata | input | 32 | Write data, valid in the data phase |
| hready | input | 1 | Bus-wide ready; previous transfer completes |
| hreadyout | output | 1 | Ready from this block (always 1) |
| hresp | output | 1 | Response (always OKAY) |
| hrdata | output | 32 | Read data in the read data phase, else 0 |

## Verification
Single transfers separated by idle cycles first test each size and lane offset. They are checked against a reference word built from overlapping byte, halfword and word writes, which would expose a wrong lane mask or byte order. Writes to both banks and to an aliased address separate bank decoding from word indexing. Back-to-back write-then-read pipelines, including a partial write followed by a read of the same word, reach the hold-register path that isolated transfers never touch. Idle, busy, deselected and `hready`-low cycles carrying write data show that nothing is stored when no transfer is accepted.

// File: rtl/ahb_sram_pkg.sv
package ahb_sram_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_WDATA = 2'd1,
        S_RDATA = 2'd2
    } phase_e;

    localparam int LANES   = 4;
    localparam int LANE_W  = 8;
    localparam int WORD_W  = LANES * LANE_W;
endpackage

// File: rtl/ahb_sram_lane_dec.sv
module ahb_sram_lane_dec
    import ahb_sram_pkg::*;
(
    input  logic [2:0]       size,
    input  logic [1:0]       offset,
    output logic [LANES-1:0] lanes
);
    always_comb begin
        unique case (size)
            3'd0:    lanes = 4'b0001 << offset;
            3'd1:    lanes = offset[1] ? 4'b1100 : 4'b0011;
            default: lanes = 4'b1111;
        endcase
    end
endmodule

// File: rtl/ahb_sram_cell.sv
module ahb_sram_cell #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          cs,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (cs) begin
            if (we) mem[addr] <= d;
            else    q <= mem[addr];
        end
    end
endmodule

// File: rtl/ahb_sram_bank.sv
module ahb_sram_bank
    import ahb_sram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              bank_en,
    input  logic              we,
    input  logic [LANES-1:0]  lane_en,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        ahb_sram_cell #(.AW(AW), .DW(LANE_W)) u_cell (
            .clk  (clk),
            .cs   (bank_en & lane_en[l]),
            .we   (we),
            .addr (addr),
            .d    (wdata[l*LANE_W +: LANE_W]),
            .q    (rdata[l*LANE_W +: LANE_W])
        );
    end
endmodule

// File: rtl/ahb_sram_banked.sv
module ahb_sram_banked
    import ahb_sram_pkg::*;
#(
    parameter int WORD_AW = 8,
    parameter int NBANK   = 2
) (
    input  logic        hclk,
    input  logic        hresetn,
    input  logic        hsel,
    input  logic [31:0] haddr,
    input  logic [1:0]  htrans,
    input  logic        hwrite,
    input  logic [2:0]  hsize,
    input  logic [31:0] hwdata,
    input  logic        hready,
    output logic        hreadyout,
    output logic        hresp,
    output logic [31:0] hrdata
);
    localparam int BW      = (NBANK > 1) ? $clog2(NBANK) : 1;
    localparam int IDX_LO  = 2;
    localparam int BANK_LO = WORD_AW + IDX_LO;

    phase_e state_q, state_d;

    // address-phase decode
    logic             accept, rd_req, wr_req;
    logic [LANES-1:0] in_lanes;
    logic [WORD_AW-1:0] in_idx;
    logic [BW-1:0]    in_bank;

    assign accept  = hsel & hready & htrans[1];
    assign rd_req  = accept & ~hwrite;
    assign wr_req  = accept & hwrite;
    assign in_idx  = haddr[IDX_LO +: WORD_AW];
    assign in_bank = (NBANK > 1) ? haddr[BANK_LO +: BW] : '0;

    ahb_sram_lane_dec u_dec (
        .size   (hsize),
        .offset (haddr[1:0]),
        .lanes  (in_lanes)
    );

    // registered address-phase fields
    logic [WORD_AW-1:0] ap_idx_q;
    logic [BW-1:0]      ap_bank_q;
    logic [LANES-1:0]   ap_lanes_q;

    // one-entry hold for a write that lost the port to a read
    logic               buf_v_q;
    logic [WORD_AW-1:0] buf_idx_q;
    logic [BW-1:0]      buf_bank_q;
    logic [LANES-1:0]   buf_lanes_q;
    logic [WORD_W-1:0]  buf_data_q;

    // state register
    always_ff @(posedge hclk or negedge hresetn) begin
        if (!hresetn) state_q <= S_IDLE;
        else          state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            S_IDLE, S_WDATA, S_RDATA: begin
                if (wr_req)      state_d = S_WDATA;
                else if (rd_req) state_d = S_RDATA;
                else             state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge hclk or negedge hresetn) begin
        if (!hresetn) begin
            ap_idx_q    <= '0;
            ap_bank_q   <= '0;
            ap_lanes_q  <= '0;
            buf_v_q     <= 1'b0;
            buf_idx_q   <= '0;
            buf_bank_q  <= '0;
            buf_lanes_q <= '0;
            buf_data_q  <= '0;
        end else begin
            if (accept) begin
                ap_idx_q   <= in_idx;
                ap_bank_q  <= in_bank;
                ap_lanes_q <= in_lanes;
            end
            if (state_q == S_WDATA && rd_req) begin
                buf_v_q     <= 1'b1;
                buf_idx_q   <= ap_idx_q;
                buf_bank_q  <= ap_bank_q;
                buf_lanes_q <= ap_lanes_q;
                buf_data_q  <= hwdata;
            end else if (!rd_req) begin
                buf_v_q     <= 1'b0;
            end
        end
    end

    // memory port arbitration: read launch > held write > direct write
    logic [WORD_AW-1:0] p_idx;
    logic [BW-1:0]      p_bank;
    logic [LANES-1:0]   p_lanes;
    logic               p_we, p_go;
    logic [WORD_W-1:0]  p_wdata;
    logic [WORD_W-1:0]  bank_rd [NBANK];
    logic [WORD_W-1:0]  sel_rd;

    always_comb begin
        p_idx   = ap_idx_q;
        p_bank  = ap_bank_q;
        p_lanes = ap_lanes_q;
        p_we    = 1'b1;
        p_go    = 1'b0;
        p_wdata = hwdata;
        hrdata  = '0;
        sel_rd  = bank_rd[ap_bank_q];
        if (rd_req) begin
            p_idx   = in_idx;
            p_bank  = in_bank;
            p_lanes = '1;
            p_we    = 1'b0;
            p_go    = 1'b1;
        end else if (buf_v_q) begin
            p_idx   = buf_idx_q;
            p_bank  = buf_bank_q;
            p_lanes = buf_lanes_q;
            p_wdata = buf_data_q;
            p_go    = 1'b1;
        end else if (state_q == S_WDATA) begin
            p_go    = 1'b1;
        end
        unique case (state_q)
            S_RDATA: begin
                for (int l = 0; l < LANES; l++) begin
                    if (buf_v_q && buf_lanes_q[l] && buf_idx_q == ap_idx_q
                        && buf_bank_q == ap_bank_q)
                        hrdata[l*LANE_W +: LANE_W] = buf_data_q[l*LANE_W +: LANE_W];
                    else
                        hrdata[l*LANE_W +: LANE_W] = sel_rd[l*LANE_W +: LANE_W];
                end
            end
            S_IDLE, S_WDATA: hrdata = '0;
            default:         hrdata = '0;
        endcase
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        ahb_sram_bank #(.AW(WORD_AW)) u_bank (
            .clk     (hclk),
            .bank_en (p_go && (p_bank == b[BW-1:0])),
            .we      (p_we),
            .lane_en (p_lanes),
            .addr    (p_idx),
            .wdata   (p_wdata),
            .rdata   (bank_rd[b])
        );
    end

    assign hreadyout = 1'b1;
    assign hresp     = 1'b0;
endmodule

// File: rtl/ahb_sram_banked_sva.sv
module ahb_sram_banked_sva
    import ahb_sram_pkg::*;
(
    input logic        hclk,
    input logic        hresetn,
    input logic        hsel,
    input logic        hready,
    input logic [1:0]  htrans,
    input logic        hwrite,
    input logic        hreadyout,
    input logic        hresp,
    input logic [31:0] hrdata,
    input phase_e      state_q,
    input logic        buf_v_q
);
    a_r2_ready_okay: assert property (@(posedge hclk) disable iff (!hresetn)
        hreadyout && !hresp);

    a_r9_rdata_quiet: assert property (@(posedge hclk) disable iff (!hresetn)
        state_q != S_RDATA |-> hrdata == 32'h0);

    a_r3_read_phase: assert property (@(posedge hclk) disable iff (!hresetn)
        (hsel && hready && htrans[1] && !hwrite) |=> state_q == S_RDATA);

    a_r10_write_phase: assert property (@(posedge hclk) disable iff (!hresetn)
        (hsel && hready && htrans[1] && hwrite) |=> state_q == S_WDATA);

    a_r7_idle_noaccept: assert property (@(posedge hclk) disable iff (!hresetn)
        (!hsel || !htrans[1]) |=> state_q == S_IDLE);

    a_r11_stall_noaccept: assert property (@(posedge hclk) disable iff (!hresetn)
        !hready |=> state_q == S_IDLE);

    // R8: the hold register is always empty when a write data phase arrives
    a_r8_hold_drained: assert property (@(posedge hclk) disable iff (!hresetn)
        state_q == S_WDATA |-> !buf_v_q);
endmodule

bind ahb_sram_banked ahb_sram_banked_sva u_sva (
    .hclk      (hclk),
    .hresetn   (hresetn),
    .hsel      (hsel),
    .hready    (hready),
    .htrans    (htrans),
    .hwrite    (hwrite),
    .hreadyout (hreadyout),
    .hresp     (hresp),
    .hrdata    (hrdata),
    .state_q   (state_q),
    .buf_v_q   (buf_v_q)
);

// File: tb/tb_ahb_sram_banked.sv
module tb_ahb_sram_banked;
    logic        hclk = 1'b0;
    logic        hresetn = 1'b0;
    logic        hsel = 1'b0;
    logic [31:0] haddr = '0;
    logic [1:0]  htrans = 2'd0;
    logic        hwrite = 1'b0;
    logic [2:0]  hsize = 3'd2;
    logic [31:0] hwdata = '0;
    logic        hready = 1'b1;
    logic        hreadyout, hresp;
    logic [31:0] hrdata;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 hclk = ~hclk;

    ahb_sram_banked dut (
        .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr),
        .htrans(htrans), .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata),
        .hready(hready), .hreadyout(hreadyout), .hresp(hresp), .hrdata(hrdata)
    );

    typedef struct packed {
        logic        wr;
        logic [1:0]  sz;
        logic [15:0] addr;
        logic [31:0] val;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 2'd2, 16'h0000, 32'h44332211, 8'd3},  // R3 word write
        '{1'b0, 2'd2, 16'h0000, 32'h44332211, 8'd3},  // R3 little-endian readback
        '{1'b1, 2'd0, 16'h0001, 32'h5566AA77, 8'd4},  // R4 lane 1 only
        '{1'b0, 2'd2, 16'h0000, 32'h4433AA11, 8'd4},
        '{1'b1, 2'd1, 16'h0002, 32'hBEEF1234, 8'd5},  // R5 upper half
        '{1'b0, 2'd2, 16'h0000, 32'hBEEFAA11, 8'd5},
        '{1'b1, 2'd1, 16'h0000, 32'h99995566, 8'd5},  // R5 lower half
        '{1'b0, 2'd2, 16'h0000, 32'hBEEF5566, 8'd5},
        '{1'b1, 2'd2, 16'h0400, 32'hCAFEF00D, 8'd6},  // R6 bank 1
        '{1'b0, 2'd2, 16'h0000, 32'hBEEF5566, 8'd6},  // R6 bank 0 intact
        '{1'b0, 2'd2, 16'h0400, 32'hCAFEF00D, 8'd6},
        '{1'b0, 2'd2, 16'h0C00, 32'hCAFEF00D, 8'd6},  // R6 alias
        '{1'b1, 2'd0, 16'h0403, 32'h77123456, 8'd4},  // R4 lane 3 only
        '{1'b0, 2'd2, 16'h0400, 32'h77FEF00D, 8'd4}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_bus();
        hsel = 1'b0; htrans = 2'd0; hwrite = 1'b0; hready = 1'b1;
    endtask

    // address phase with junk hwdata, data phase with real data (R10)
    task automatic do_write(input logic [31:0] a, input logic [2:0] sz, input logic [31:0] d);
        @(negedge hclk);
        hsel = 1'b1; htrans = 2'd2; hwrite = 1'b1; hsize = sz; haddr = a; hwdata = ~d;
        @(negedge hclk);
        idle_bus(); hwdata = d;
        check("R9", hrdata, 32'h0);
        @(negedge hclk);
        hwdata = 32'hDEAD_0000;
    endtask

    task automatic do_read(input logic [31:0] a, input logic [31:0] exp, input string req);
        @(negedge hclk);
        hsel = 1'b1; htrans = 2'd2; hwrite = 1'b0; hsize = 3'd2; haddr = a;
        @(negedge hclk);
        idle_bus();
        check(req, hrdata, exp);
        check("R2", {31'h0, hreadyout, hresp}, 32'h2);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge hclk);
        // R1 reset state
        check("R1", hrdata, 32'h0);
        check("R1", {31'h0, hreadyout}, 32'h1);
        check("R1", {31'h0, hresp}, 32'h0);
        hresetn = 1'b1;

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VEC[i].req);
            if (VEC[i].wr) do_write({16'h0, VEC[i].addr}, {1'b0, VEC[i].sz}, VEC[i].val);
            else           do_read({16'h0, VEC[i].addr}, VEC[i].val, tag);
        end

        // R7: idle, busy and deselected cycles carrying write data
        @(negedge hclk);
        hsel = 1'b1; htrans = 2'd0; hwrite = 1'b1; hsize = 3'd2; haddr = 32'h0;
        @(negedge hclk);
        hwdata = 32'h0BAD0BAD; htrans = 2'd1;
        @(negedge hclk);
        hsel = 1'b0; htrans = 2'd2;
        @(negedge hclk);
        idle_bus();
        check("R9", hrdata, 32'h0);
        do_read(32'h0, 32'hBEEF5566, "R7");

        // R11: hready low blocks a NONSEQ write
        @(negedge hclk);
        hsel = 1'b1; htrans = 2'd2; hwrite = 1'b1; hsize = 3'd2; haddr = 32'h0; hready = 1'b0;
        @(negedge hclk);
        idle_bus(); hwdata = 32'h0BADF00D;
        @(negedge hclk);
        do_read(32'h0, 32'hBEEF5566, "R11");

        // R8: pipelined write then read of the same word
        do_write(32'h14, 3'd2, 32'hA5A5A5A5);
        @(negedge hclk);
        hsel = 1'b1; htrans = 2'd2; hwrite = 1'b1; hsize = 3'd2; haddr = 32'h10; hwdata = 32'h0;
        @(negedge hclk);
        hwrite = 1'b0; haddr = 32'h10; hwdata = 32'h01020304;
        @(negedge hclk);
        check("R8", hrdata, 32'h01020304);
        hwrite = 1'b0; haddr = 32'h14;
        @(negedge hclk);
        check("R8", hrdata, 32'hA5A5A5A5);
        hwrite = 1'b1; haddr = 32'h18;
        @(negedge hclk);
        hwrite = 1'b0; haddr = 32'h18; hwdata = 32'h0B0B0B0B;
        @(negedge hclk);
        check("R8", hrdata, 32'h0B0B0B0B);
        idle_bus();
        // partial write merged with older bytes
        @(negedge hclk);
        hsel = 1'b1; htrans = 2'd2; hwrite = 1'b1; hsize = 3'd0; haddr = 32'h11;
        @(negedge hclk);
        hwrite = 1'b0; hsize = 3'd2; haddr = 32'h10; hwdata = 32'h1122EE44;
        @(negedge hclk);
        check("R8", hrdata, 32'h0102EE04);
        idle_bus();
        @(negedge hclk);
        check("R9", hrdata, 32'h0);
        do_read(32'h10, 32'h0102EE04, "R8");
        do_read(32'h18, 32'h0B0B0B0B, "R8");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule